// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block watches an I2C bus from the slave side and decides whether the first address phase of a transfer is meant for this device. SCL and SDA are taken in asynchronously, synchronized into the system clock domain, and edge-detected. From the edges the block finds START and STOP conditions and shifts in the address byte that follows a START. It compares that byte against up to three targets: a primary own address, a secondary own address and the general-call address. The secondary and general-call comparisons each have their own enable.

With 10-bit addressing the first byte must be the header 11110 followed by the two upper bits of the own address and a 0. The block acknowledges the header, then takes a second byte and compares it with the lower eight address bits. On a hit the block pulls SDA low for the acknowledge bit when acknowledges are enabled. It raises a one-cycle match pulse with flags saying which comparator hit, and it latches the transfer direction.

Configuration comes in on plain input ports and must stay stable for the length of a transfer. There is no streaming data path. The match report is a status pulse plus held flags, so the block has no valid/ready handshake and applies no back-pressure. The acknowledge output is an active-high "pull SDA low" request for an external open-drain pad.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the block is idle: `sda_pull_low`, `hit_pulse`, all three hit flags and `dir_read` are 0.
- R2: A START (SDA falling while SCL is high) begins address reception. A repeated START, even in the middle of a byte, throws away the partial byte and restarts reception from the first bit.
- R3: Address bits are sampled MSB first on SCL rising edges. In 7-bit mode a primary hit is byte bits 7..1 equal to `own_addr[6:0]`, and byte bit 0 is latched into `dir_read` (1 = read).
- R4: When `second_en` is 1, byte bits 7..1 equal to `own_addr2` give a secondary hit. When it is 0, that comparison never hits.
- R5: When `gcall_en` is 1, a first byte of 0x00 gives a general-call hit. When it is 0, that comparison never hits.
- R6: When `ten_bit` is 1, a first byte equal to {11110, `own_addr[9:8]`, 0} is a header hit. It is acknowledged, and the next byte is compared with `own_addr[7:0]`. A match there is a primary hit with `dir_read` = 0.
- R7: On a hit, or on a header hit, with `ack_en` = 1, `sda_pull_low` rises after the SCL falling edge that ends bit 8 and falls after the SCL falling edge that ends the ninth bit. With `ack_en` = 0 it stays low.
- R8: On a mismatch the block does not acknowledge, and it ignores all further bytes until the next START, even bytes that would match.
- R9: Each full match gives exactly one `hit_pulse` of one clock cycle. The flags `hit_primary`, `hit_second` and `hit_gcall` show every comparator that hit, stay set until the next START, and are cleared by that START.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle. Bits clocked after it without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| ten_bit | input | 1 | 1 selects 10-bit addressing for the primary address |
| own_addr | input | 10 | Primary own address; only bits 6..0 are used in 7-bit mode |
| second_en | input | 1 | Enables the secondary address comparison |
| own_addr2 | input | 7 | Secondary 7-bit own address |
| gcall_en | input | 1 | Enables the general-call comparison |
| ack_en | input | 1 | Allows acknowledges to be driven |
| sda_pull_low | output | 1 | 1 asks the pad to pull SDA low (acknowledge) |
| hit_pulse | output | 1 | One-cycle pulse on a completed address match |
| hit_primary | output | 1 | Primary address matched (7-bit or full 10-bit) |
| hit_second | output | 1 | Secondary address matched |
| hit_gcall | output | 1 | General-call address matched |
| dir_read | output | 1 | Latched direction bit of the matched address, 1 = read |

## Verification
The assertions rely on three things about the inputs: SCL and SDA change slowly next to the system clock, the master changes SDA only while SCL is low except when it makes a START or STOP, and the configuration ports do not move during a transfer. The stimulus holds every bus phase for ten system clocks and changes configuration only after a STOP. It draws first bytes from a mix that favours the primary, secondary, general-call and header values, so that the hit paths are exercised and not just reached by chance. Directed cases cover a repeated START in the middle of a byte, bits clocked after a STOP, and bytes sent after a mismatch.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    AM_IDLE  = 2'd0,
    AM_BYTE1 = 2'd1,
    AM_BYTE2 = 2'd2,
    AM_HOLD  = 2'd3
  } am_state_t;

  typedef struct packed {
    logic prim;
    logic sec;
    logic gc;
  } am_hit_t;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q     = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7,
  parameter int BYTE_W  = 8
) (
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               ten_bit,
  input  logic [ADDR_W-1:0]  own_addr,
  input  logic               second_en,
  input  logic [SHORT_W-1:0] own_addr2,
  input  logic               gcall_en,
  output am_hit_t            hit7,
  output logic               hdr_hit,
  output logic               low_hit
);
  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int PFX_W = BYTE_W - HI_W - 1;

  logic [BYTE_W-1:0] header;

  assign header = {{(PFX_W-1){1'b1}}, 1'b0, own_addr[ADDR_W-1:BYTE_W], 1'b0};

  always_comb begin
    hit7.prim = ~ten_bit & (rx_byte[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
    hit7.sec  = second_en & (rx_byte[BYTE_W-1:1] == own_addr2);
    hit7.gc   = gcall_en & (rx_byte == '0);
    hdr_hit   = ten_bit & (rx_byte == header);
    low_hit   = (rx_byte == own_addr[BYTE_W-1:0]);
  end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ack_en,
  input  am_hit_t           hit7,
  input  logic              hdr_hit,
  input  logic              low_hit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_drive,
  output logic              hit_pulse,
  output am_hit_t           hit_flags,
  output logic              dir_read
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  am_state_t        state, after_ack;
  logic [CNT_W-1:0] bitcnt;
  logic             any7;

  assign any7 = hit7.prim | hit7.sec | hit7.gc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= AM_IDLE;
      after_ack <= AM_HOLD;
      bitcnt    <= '0;
      rx_byte   <= '0;
      ack_drive <= 1'b0;
      hit_pulse <= 1'b0;
      hit_flags <= '0;
      dir_read  <= 1'b0;
    end else begin
      hit_pulse <= 1'b0;
      if (start_det) begin
        state     <= AM_BYTE1;
        bitcnt    <= '0;
        rx_byte   <= '0;
        ack_drive <= 1'b0;
        hit_flags <= '0;
      end else if (stop_det) begin
        state     <= AM_IDLE;
        bitcnt    <= '0;
        ack_drive <= 1'b0;
      end else if (state == AM_BYTE1 || state == AM_BYTE2) begin
        if (scl_rise && bitcnt < LAST_BIT) begin
          rx_byte <= {rx_byte[BYTE_W-2:0], sda_lvl};
          bitcnt  <= bitcnt + 1'b1;
        end else if (scl_fall && bitcnt == LAST_BIT) begin
          bitcnt <= ACK_BIT;
          if (state == AM_BYTE1 && any7) begin
            hit_flags <= hit7;
            hit_pulse <= 1'b1;
            dir_read  <= rx_byte[0];
            ack_drive <= ack_en;
            after_ack <= AM_HOLD;
          end else if (state == AM_BYTE1 && hdr_hit) begin
            ack_drive <= ack_en;
            after_ack <= AM_BYTE2;
          end else if (state == AM_BYTE2 && low_hit) begin
            hit_flags <= '{prim: 1'b1, sec: 1'b0, gc: 1'b0};
            hit_pulse <= 1'b1;
            dir_read  <= 1'b0;
            ack_drive <= ack_en;
            after_ack <= AM_HOLD;
          end else begin
            state <= AM_HOLD;
          end
        end else if (scl_fall && bitcnt == ACK_BIT) begin
          ack_drive <= 1'b0;
          bitcnt    <= '0;
          state     <= after_ack;
        end
      end
    end
  end

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == AM_BYTE1 && bitcnt == '0 && !ack_drive));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state == AM_IDLE && !ack_drive));

  // R7
  ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> ($past(scl_fall) && ack_en));

  // R8
  hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AM_HOLD && $past(state) == AM_HOLD && !$past(start_det)) |-> !$rose(ack_drive));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |=> !hit_pulse);

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |-> (hit_flags.prim | hit_flags.sec | hit_flags.gc));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SHORT_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               ten_bit,
  input  logic [ADDR_W-1:0]  own_addr,
  input  logic               second_en,
  input  logic [SHORT_W-1:0] own_addr2,
  input  logic               gcall_en,
  input  logic               ack_en,
  output logic               sda_pull_low,
  output logic               hit_pulse,
  output logic               hit_primary,
  output logic               hit_second,
  output logic               hit_gcall,
  output logic               dir_read
);
  localparam int BYTE_W = SHORT_W + 1;

  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              hdr_hit, low_hit;
  logic [BYTE_W-1:0] rx_byte;
  am_hit_t           hit7, flags;

  i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_am_cmp #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W)) u_cmp (
    .rx_byte(rx_byte), .ten_bit(ten_bit), .own_addr(own_addr),
    .second_en(second_en), .own_addr2(own_addr2), .gcall_en(gcall_en),
    .hit7(hit7), .hdr_hit(hdr_hit), .low_hit(low_hit)
  );

  i2c_am_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_en(ack_en), .hit7(hit7), .hdr_hit(hdr_hit), .low_hit(low_hit),
    .rx_byte(rx_byte), .ack_drive(sda_pull_low), .hit_pulse(hit_pulse),
    .hit_flags(flags), .dir_read(dir_read)
  );

  assign hit_primary = flags.prim;
  assign hit_second  = flags.sec;
  assign hit_gcall   = flags.gc;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sda_pull_low && !hit_pulse));

  // R7
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_in);
endmodule

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ten_bit = 1'b0, second_en = 1'b0, gcall_en = 1'b0, ack_en = 1'b1;
  logic [9:0] own_addr = 10'h000;
  logic [6:0] own_addr2 = 7'h00;
  logic sda_pull_low, hit_pulse, hit_primary, hit_second, hit_gcall, dir_read;
  wire  sda_bus = m_sda & ~sda_pull_low;

  int total = 0, bad = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .ten_bit(ten_bit), .own_addr(own_addr), .second_en(second_en),
    .own_addr2(own_addr2), .gcall_en(gcall_en), .ack_en(ack_en),
    .sda_pull_low(sda_pull_low), .hit_pulse(hit_pulse), .hit_primary(hit_primary),
    .hit_second(hit_second), .hit_gcall(hit_gcall), .dir_read(dir_read)
  );

  always @(posedge clk) if (hit_pulse) pulses <= pulses + 1;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // ack slot: drive_mid = pull request while SCL low before the 9th rise,
  // seen = line level during SCL high, after = pull request after the 9th fall
  task automatic ack_slot(output bit seen, output bit drive_mid, output bit after);
    m_sda = 1'b1; wq();
    drive_mid = sda_pull_low;
    m_scl = 1'b1; wq();
    seen = ~sda_bus;
    m_scl = 1'b0; wq();
    after = sda_pull_low;
  endtask

  typedef struct {
    bit ack1; bit ack2; int npulse; bit prim; bit sec; bit gc; bit rw;
  } exp_t;

  function automatic exp_t model(input logic [7:0] b1, input logic [7:0] b2, input bit send2);
    exp_t e;
    bit p7, s7, g7, hdr, h7, lo;
    p7  = !ten_bit && (b1[7:1] == own_addr[6:0]);
    s7  = second_en && (b1[7:1] == own_addr2);
    g7  = gcall_en && (b1 == 8'h00);
    hdr = ten_bit && (b1 == {5'b11110, own_addr[9:8], 1'b0});
    h7  = p7 | s7 | g7;
    lo  = send2 && !h7 && hdr && (b2 == own_addr[7:0]);
    e.ack1 = ack_en && (h7 || hdr);
    e.ack2 = ack_en && lo;
    e.npulse = (h7 || lo) ? 1 : 0;
    e.prim = p7 | lo;
    e.sec  = s7;
    e.gc   = g7;
    e.rw   = h7 ? b1[0] : 1'b0;
    return e;
  endfunction

  task automatic frame(input logic [7:0] b1, input logic [7:0] b2, input bit send2);
    exp_t e;
    bit a1, d1, r1, a2, d2, r2;
    bit rw_before;
    rw_before = dir_read;
    e = model(b1, b2, send2);
    pulses = 0;
    do_start();
    send_byte(b1);
    ack_slot(a1, d1, r1);
    chk("R7 ack on first byte", a1, e.ack1);
    chk("R7 pull held before ninth rise", d1, e.ack1);
    chk("R7 pull released after ninth fall", r1, 0);
    a2 = 0;
    if (send2) begin
      send_byte(b2);
      ack_slot(a2, d2, r2);
      chk("R6 R8 ack on second byte", a2, e.ack2);
      chk("R7 release after second ack", r2, 0);
    end
    do_stop();
    wq();
    chk("R9 pulse count", pulses, e.npulse);
    chk("R3 R6 primary flag", hit_primary, e.prim);
    chk("R4 secondary flag", hit_second, e.sec);
    chk("R5 general-call flag", hit_gcall, e.gc);
    chk("R3 direction", dir_read, (e.npulse != 0) ? e.rw : rw_before);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk("R1 reset pull", sda_pull_low, 0);
    chk("R1 reset flags", {hit_primary, hit_second, hit_gcall, dir_read}, 0);
    rst_n = 1'b1;
    wq();
    chk("R1 idle pull after reset", sda_pull_low, 0);
    chk("R1 idle pulse after reset", pulses, 0);

    // directed: 7-bit primary read
    own_addr = 10'h05A; ten_bit = 0; ack_en = 1;
    frame({7'h5A, 1'b1}, 8'h00, 0);
    // R4 / R5 enables off and on
    own_addr2 = 7'h33; second_en = 0; gcall_en = 0;
    frame({7'h33, 1'b0}, 8'h00, 0);
    frame(8'h00, 8'h00, 0);
    second_en = 1; gcall_en = 1;
    frame({7'h33, 1'b1}, 8'h00, 0);
    frame(8'h00, 8'h00, 0);
    // R8: mismatch then a matching byte is ignored
    frame(8'hEE, {7'h5A, 1'b0}, 1);
    // R6: 10-bit, header ack then low byte
    ten_bit = 1; own_addr = 10'h2C7;
    frame({5'b11110, 2'b10, 1'b0}, 8'hC7, 1);
    frame({5'b11110, 2'b10, 1'b0}, 8'hC6, 1);
    frame({5'b11110, 2'b01, 1'b0}, 8'hC7, 1);
    // R7: ack disabled
    ack_en = 0;
    frame({5'b11110, 2'b10, 1'b0}, 8'hC7, 1);
    ack_en = 1; ten_bit = 0; own_addr = 10'h05A;

    // R2: repeated START in mid-byte restarts reception
    begin
      bit a, d, r;
      pulses = 0;
      do_start();
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      do_start();
      send_byte({7'h5A, 1'b0});
      ack_slot(a, d, r);
      chk("R2 ack after repeated start", a, 1);
      do_stop(); wq();
      chk("R2 single pulse after repeated start", pulses, 1);
    end

    // R10: bits after STOP without START are not acknowledged
    begin
      bit a, d, r;
      pulses = 0;
      send_byte({7'h5A, 1'b0});
      ack_slot(a, d, r);
      chk("R10 no ack after stop", a, 0);
      chk("R10 no pulse after stop", pulses, 0);
      do_stop();
    end

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [7:0] b1, b2;
      int sel;
      ten_bit   = $urandom_range(0, 1);
      own_addr  = 10'($urandom);
      own_addr2 = 7'($urandom);
      second_en = $urandom_range(0, 1);
      gcall_en  = $urandom_range(0, 1);
      ack_en    = ($urandom_range(0, 3) != 0);
      sel = $urandom_range(0, 4);
      case (sel)
        0: b1 = {own_addr[6:0], 1'($urandom)};
        1: b1 = {own_addr2, 1'($urandom)};
        2: b1 = 8'h00;
        3: b1 = {5'b11110, own_addr[9:8], 1'b0};
        default: b1 = 8'($urandom);
      endcase
      b2 = ($urandom_range(0, 2) != 0) ? own_addr[7:0] : 8'($urandom);
      frame(b1, b2, ($urandom_range(0, 1) == 1) || sel == 3);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule